// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block forms the byte a flash device returns on reads while an embedded program or erase is running. The operation controller reports when a program starts, when a block-erase command has been entered, when the operation finishes, and whether it failed. It also says whether every block chosen for erase is protected. The host bus supplies a strobe for each read access. Three status bits are produced: a bit that flips on every read while busy, a sticky failure bit, and a bit that drops low while an entered erase is still waiting to begin.

A flag on the output tells the bus whether reads should return this status byte or array data. A program or an erase holds the status view until the controller reports completion. A failure keeps the status view until a reset command clears it. A protected-only erase shows a busy window of fixed length and then hands the bus back to the array. It does not raise an error. The erase wait window and the protected busy window are given in microseconds. They are converted to clock cycles from a clock-frequency parameter.

Top module: `pe_status_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `show_status_o` is 0 and `status_o` equals 8'h08: only bit 3 is set.
- R2: In idle, an `op_start_i` pulse sets `show_status_o` to 1 from the next cycle. A start or erase command given while an operation is already running is ignored.
- R3: Bit 6 of `status_o` is the toggle bit. It inverts after each cycle in which `rd_strobe_i` is high while `show_status_o` is 1. It keeps its value in every other cycle.
- R4: In the busy state, `op_done_i` with `op_fail_i` low returns the block to idle. `show_status_o` is 0 in the next cycle unless an earlier error is still held.
- R5: Bit 5 of `status_o` is the error bit. It is 0 during an operation that completes without failure. It becomes 1, and `show_status_o` stays 1, in the cycle after `op_done_i` arrives together with `op_fail_i` in the busy state.
- R6: `err_clr_i` clears the error bit from the next cycle. If no operation is running, the bus returns to array data (`show_status_o` = 0). A failure reported in the same cycle takes priority over the clear.
- R7: Bit 3 of `status_o` is the erase-wait bit. An `erase_cmd_i` pulse in idle makes it read 0 for exactly ERASE_WAIT_US × CLK_HZ / 10^6 cycles. After that it reads 1 and the erase becomes busy.
- R8: If `erase_prot_i` is high when the erase wait ends, the status view stays up for PROT_BUSY_US × CLK_HZ / 10^6 cycles and then drops. The toggle bit keeps working during this window. `op_done_i` and `op_fail_i` are ignored, so no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start_i | input | 1 | Pulse: a byte program begins |
| erase_cmd_i | input | 1 | Pulse: last block-erase command entered |
| erase_prot_i | input | 1 | All blocks selected for erase are protected |
| op_done_i | input | 1 | Pulse: embedded operation finished |
| op_fail_i | input | 1 | Qualifies `op_done_i` as a failure |
| err_clr_i | input | 1 | Reset command: clears the error bit |
| rd_strobe_i | input | 1 | One-cycle pulse per bus read access |
| show_status_o | output | 1 | 1: reads return `status_o`; 0: reads return array data |
| status_o | output | 8 | Status byte: toggle bit 6, error bit 5, erase-wait bit 3, other bits 0 |

## Verification
The bench builds the block with CLK_HZ = 100000, ERASE_WAIT_US = 100 and PROT_BUSY_US = 50. This gives a 10-cycle erase wait and a 5-cycle protected busy window, short enough that both windows can be observed edge to edge in a few hundred cycles. With these values the bench can exercise reads placed in the first and last cycle of each window, and commands issued while another operation is running. It also covers a failure report and an error clear arriving in the same cycle, and a protected erase that receives done-with-fail while its busy window is open.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EWAIT = 2'd1,
        ST_BUSY  = 2'd2,
        ST_FAKE  = 2'd3
    } pe_state_e;

    typedef struct packed {
        logic       rsv7;
        logic       toggle;
        logic       error;
        logic       rsv4;
        logic       ewait_n;
        logic [2:0] rsv_lo;
    } pe_status_t;

    // Microseconds to clock cycles, never less than one cycle.
    function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned usec);
        longint unsigned c;
        c = (clk_hz * usec) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/pe_window_timer.sv
module pe_window_timer #(
    parameter int unsigned CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expire_o
);
    localparam int unsigned W = $clog2(CYC + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= W'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == W'(1));

endmodule

// File: rtl/pe_toggle_cell.sv
module pe_toggle_cell (
    input  logic clk,
    input  logic rst,
    input  logic flip_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else if (flip_i) begin
            q_o <= ~q_o;
        end
    end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
    import pe_status_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 50000000,
    parameter longint unsigned ERASE_WAIT_US = 100,
    parameter longint unsigned PROT_BUSY_US  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_start_i,
    input  logic       erase_cmd_i,
    input  logic       erase_prot_i,
    input  logic       op_done_i,
    input  logic       op_fail_i,
    input  logic       err_clr_i,
    input  logic       rd_strobe_i,
    output logic       show_status_o,
    output logic [7:0] status_o
);
    localparam int unsigned EWAIT_CYC = us_to_cycles(CLK_HZ, ERASE_WAIT_US);
    localparam int unsigned PROT_CYC  = us_to_cycles(CLK_HZ, PROT_BUSY_US);

    pe_state_e  st_q, st_d;
    logic       err_q;
    logic       tog_q;
    logic       ewait_load, prot_load;
    logic       ewait_exp, prot_exp;
    logic       fail_evt;
    pe_status_t stat;

    pe_window_timer #(.CYC(EWAIT_CYC)) u_ewait_tmr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ewait_load),
        .expire_o(ewait_exp)
    );

    pe_window_timer #(.CYC(PROT_CYC)) u_prot_tmr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (prot_load),
        .expire_o(prot_exp)
    );

    pe_toggle_cell u_tog (
        .clk   (clk),
        .rst   (rst),
        .flip_i(rd_strobe_i && show_status_o),
        .q_o   (tog_q)
    );

    always_comb begin
        st_d       = st_q;
        ewait_load = 1'b0;
        prot_load  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (erase_cmd_i) begin
                    st_d       = ST_EWAIT;
                    ewait_load = 1'b1;
                end else if (op_start_i) begin
                    st_d = ST_BUSY;
                end
            end
            ST_EWAIT: begin
                if (ewait_exp) begin
                    if (erase_prot_i) begin
                        st_d      = ST_FAKE;
                        prot_load = 1'b1;
                    end else begin
                        st_d = ST_BUSY;
                    end
                end
            end
            ST_BUSY: begin
                if (op_done_i) st_d = ST_IDLE;
            end
            ST_FAKE: begin
                if (prot_exp) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign fail_evt = (st_q == ST_BUSY) && op_done_i && op_fail_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (fail_evt) begin
                err_q <= 1'b1;
            end else if (err_clr_i) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat         = '0;
        stat.toggle  = tog_q;
        stat.error   = err_q;
        stat.ewait_n = (st_q != ST_EWAIT);
    end

    assign status_o      = stat;
    assign show_status_o = (st_q != ST_IDLE) || err_q;

endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk
    import pe_status_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_start_i,
    input logic       erase_cmd_i,
    input logic       op_done_i,
    input logic       op_fail_i,
    input logic       err_clr_i,
    input logic       rd_strobe_i,
    input logic       show_status_o,
    input logic [7:0] status_o,
    input pe_state_e  st_q
);
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_view_R1: assert (!show_status_o && status_o == 8'h08)
                else $error("R1 reset view wrong");
        end
    end

    assert_start_shows_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && op_start_i && !erase_cmd_i) |=> show_status_o);

    assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe_i && show_status_o) |=> (status_o[6] != $past(status_o[6])));

    assert_toggle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe_i |=> $stable(status_o[6]));

    assert_fail_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && op_done_i && op_fail_i) |=> (status_o[5] && show_status_o));

    assert_clr_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (err_clr_i && !(st_q == ST_BUSY && op_done_i && op_fail_i)) |=> !status_o[5]);

    assert_ewait_entry_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[3]) |-> $past(erase_cmd_i));

    assert_fake_no_err_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FAKE && op_done_i && op_fail_i && !err_clr_i) |=> $stable(status_o[5]));

endmodule

bind pe_status_gen pe_status_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .op_start_i   (op_start_i),
    .erase_cmd_i  (erase_cmd_i),
    .op_done_i    (op_done_i),
    .op_fail_i    (op_fail_i),
    .err_clr_i    (err_clr_i),
    .rd_strobe_i  (rd_strobe_i),
    .show_status_o(show_status_o),
    .status_o     (status_o),
    .st_q         (st_q)
);

// File: tb/pe_status_gen_tb_top.sv
module pe_status_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EW_CYC = 10;
    localparam int PB_CYC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_start = 0, erase_cmd = 0, erase_prot = 0;
    logic op_done = 0, op_fail = 0, err_clr = 0, rd = 0;
    logic       show;
    logic [7:0] stat;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_status_gen #(
        .CLK_HZ(100000), .ERASE_WAIT_US(100), .PROT_BUSY_US(50)
    ) dut_i (
        .clk(clk), .rst(rst), .op_start_i(op_start), .erase_cmd_i(erase_cmd),
        .erase_prot_i(erase_prot), .op_done_i(op_done), .op_fail_i(op_fail),
        .err_clr_i(err_clr), .rd_strobe_i(rd), .show_status_o(show), .status_o(stat)
    );

    // Behavioural reference: 0 idle, 1 erase wait, 2 busy, 3 protected busy
    int m_st = 0, m_cnt = 0;
    bit m_tog = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_tog = 0; m_err = 0;
        end else begin
            if (rd && (m_st != 0 || m_err)) m_tog = !m_tog;
            if (m_st == 2 && op_done && op_fail) m_err = 1;
            else if (err_clr) m_err = 0;
            case (m_st)
                0: if (erase_cmd) begin m_st = 1; m_cnt = EW_CYC; end
                   else if (op_start) m_st = 2;
                1: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (erase_prot) begin m_st = 3; m_cnt = PB_CYC; end
                        else m_st = 2;
                    end
                end
                2: if (op_done) m_st = 0;
                default: begin
                    m_cnt--;
                    if (m_cnt == 0) m_st = 0;
                end
            endcase
        end
    end

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: show/status actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done_flag) begin
            logic [7:0] e;
            e = 8'h00;
            e[6] = m_tog;
            e[5] = m_err;
            e[3] = (m_st != 1);
            check(phase, {show, stat}, {(m_st != 0 || m_err), e});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1; @(negedge clk); s = 0;
    endtask

    task automatic reads(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            pulse(rd);
            step(gap);
        end
    endtask

    initial begin
        step(3);
        phase = "R1";
        check("R1", {show, stat}, 9'h008);
        @(negedge clk); rst = 0;
        step(1);
        check("R1", {show, stat}, 9'h008);
        phase = "R3";
        reads(3, 0);                      // no status view: toggle holds
        phase = "R2";
        pulse(op_start);
        step(1);
        check("R2", {1'b0, show}, 2'b01);
        phase = "R3";
        reads(4, 1);
        reads(3, 0);
        phase = "R2";
        pulse(erase_cmd);                 // ignored while busy
        pulse(op_start);
        step(2);
        phase = "R4";
        pulse(op_done);
        step(2);
        phase = "R5";
        pulse(op_start);
        reads(2, 0);
        @(negedge clk); op_done = 1; op_fail = 1;
        @(negedge clk); op_done = 0; op_fail = 0;
        check("R5", {show, stat[5]}, 2'b11);
        reads(3, 1);
        pulse(op_start);                  // err held, idle: accepted
        step(2);
        phase = "R6";
        pulse(err_clr);
        step(2);
        pulse(op_done);
        step(2);
        check("R6", {show, stat[5]}, 2'b00);
        phase = "R7";
        pulse(erase_cmd);
        reads(4, 2);
        step(8);
        check("R7", {8'h0, stat[3]}, 9'h001);
        reads(2, 0);
        pulse(op_done);
        step(2);
        phase = "R8";
        erase_prot = 1;
        pulse(erase_cmd);
        step(EW_CYC - 1);
        reads(2, 0);
        @(negedge clk); op_done = 1; op_fail = 1;
        @(negedge clk); op_done = 0; op_fail = 0;
        step(PB_CYC + 2);
        check("R8", {show, stat[5]}, 2'b00);
        erase_prot = 0;
        phase = "R6";
        pulse(op_start);
        @(negedge clk); op_done = 1; op_fail = 1; err_clr = 1;
        @(negedge clk); op_done = 0; op_fail = 0; err_clr = 0;
        step(2);
        pulse(err_clr);
        step(2);
        phase = "R1";
        @(negedge clk); rst = 1;
        step(2);
        check("R1", {show, stat}, 9'h008);
        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        done_flag = 1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule